// File: doc/BRIEF.md
# Reconfigurable Add-Compare-Select State Metric Recursion

This block holds the state metric vector of a Max-Log-MAP soft decoder and advances it by one trellis step per accepted set of branch metrics. A fixed array of add-compare-select cells, sized for the largest trellis (16 states by default), serves convolutional codes with constraint length 3, 4 or 5, which have 4, 8 or 16 states. The same array runs either the forward recursion (each state takes the larger of its two predecessor metrics plus branch metric) or the backward recursion (each state takes the larger of its two successor metrics plus branch metric). No log correction term is applied.

Between cycles the cell outputs pass through a permutation network chosen by constraint length and direction. For smaller codes this network packs the active states onto the subset of cells whose fixed wiring matches the smaller trellis. Every feedback slot it does not drive is forced to zero. A start pulse latches the configuration and loads the initial metrics; each following valid cycle performs one recursion step. The output is always presented in logical state order, so the consumer never sees the internal placement.

Top module: `acs_recursion_bank`

## Requirements
- R1: While reset is asserted and after it is released, all lanes of `sm_o` read zero and `sm_vld_o` is low until the first start.
- R2: A cycle with `start_i` high latches the configuration and, one cycle later, raises `sm_vld_o` with the initial vector. Forward: state 0 holds 0 and every other active state holds -2^(WS-2) (-1024 by default). Backward: every active state holds 0. `start_i` wins over `bm_vld_i` in the same cycle.
- R3: Forward (`cfg_bwd_i`=0), one cycle after `bm_vld_i`, state s of an N-state code holds max(old[(2s) mod N] + bm0[s], old[(2s+1) mod N] + bm1[s]), and `sm_vld_o` is high.
- R4: Backward (`cfg_bwd_i`=1), one cycle after `bm_vld_i`, state s holds max(old[s/2] + bm0[s], old[s/2 + N/2] + bm1[s]), and `sm_vld_o` is high.
- R5: The state count is N = 2^(K-1), where K is `cfg_k_i`. A value below 3 is treated as 3, and a value above 5 is treated as 5.
- R6: Lanes s >= N of `sm_o` read zero. Branch metric lanes s >= N have no effect on any output.
- R7: Changes on `cfg_k_i` and `cfg_bwd_i` while `start_i` is low do not alter the running recursion.
- R8: `bm_vld_i` before the first start after reset is ignored: `sm_o` stays zero and `sm_vld_o` stays low.
- R9: In a cycle with neither `start_i` nor `bm_vld_i`, `sm_vld_o` is low in the next cycle and `sm_o` is unchanged.
- R10: Lane s of every vector port occupies bits [s*W +: W] in two's complement, where W is WB for branch metrics and WS for state metrics.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a window: latch configuration, load initial metrics |
| cfg_k_i | input | 3 | Constraint length (3, 4 or 5; clamped) |
| cfg_bwd_i | input | 1 | 0 forward recursion, 1 backward recursion |
| bm_vld_i | input | 1 | Branch metrics valid: perform one recursion step |
| bm0_i | input | NS*WB | Branch metric for candidate 0, per logical state |
| bm1_i | input | NS*WB | Branch metric for candidate 1, per logical state |
| sm_o | output | NS*WS | Current state metrics in logical state order |
| sm_vld_o | output | 1 | State vector was updated or loaded in the previous cycle |

## Verification
The bench sweeps every constraint length in both directions with pseudo-random branch metrics on all lanes, including the inactive ones. A permutation that put a 4- or 8-state trellis on the wrong cells would therefore show mixed-up metrics or leakage from unused lanes. Start is issued together with a valid step, so a design that let the step win would miss the initial vector. The configuration inputs are toggled mid-window and out-of-range constraint lengths are used at start; a design that re-read the configuration or decoded it wrongly would switch trellis size. Idle cycles and valid cycles before the first start check that metrics neither drift nor update spuriously. Runs with all-extreme branch metrics check that the signed compare picks the larger sum.

// File: rtl/acs_rec_pkg.sv
package acs_rec_pkg;

  // Smallest supported constraint length
  localparam int K_MIN = 3;

  typedef enum logic {DIR_FWD = 1'b0, DIR_BWD = 1'b1} rec_dir_e;

  // Place logical state s of an n-state trellis onto an ns-wide cell array:
  // low bits stay, the top state bit moves to the top array bit.
  function automatic int spread_idx(int s, int n, int ns);
    return (s % (n / 2)) + ((s >= n / 2) ? ns / 2 : 0);
  endfunction

  // Inverse of spread_idx; -1 when array index i carries no state of n.
  function automatic int gather_idx(int i, int n, int ns);
    int lo;
    lo = i % (ns / 2);
    if (lo >= n / 2) return -1;
    return lo + ((i >= ns / 2) ? n / 2 : 0);
  endfunction

  // Source index for a permutation lane.
  // kind 0: branch metric to cell, 1: cell output to feedback slot,
  // kind 2: feedback slot to logical output view.
  function automatic int src_idx(int kind, bit bwd, int i, int n, int ns);
    int id_s;
    int sp_s;
    int ga_s;
    id_s = (i < n) ? i : -1;
    sp_s = (i < n) ? spread_idx(i, n, ns) : -1;
    ga_s = gather_idx(i, n, ns);
    if (kind == 0) return bwd ? id_s : ga_s;
    if (kind == 1) return bwd ? ga_s : sp_s;
    return bwd ? sp_s : id_s;
  endfunction

endpackage

// File: rtl/acs_cell.sv
module acs_cell #(
  parameter int WS = 12,
  parameter int WB = 6
) (
  input  logic signed [WS-1:0] m0_i,
  input  logic signed [WS-1:0] m1_i,
  input  logic signed [WB-1:0] b0_i,
  input  logic signed [WB-1:0] b1_i,
  output logic signed [WS-1:0] sm_o
);
  localparam int WX = WS - WB;

  logic signed [WS-1:0] cand0;
  logic signed [WS-1:0] cand1;

  assign cand0 = m0_i + {{WX{b0_i[WB-1]}}, b0_i};
  assign cand1 = m1_i + {{WX{b1_i[WB-1]}}, b1_i};

  always_comb begin
    if (cand1 > cand0) sm_o = cand1;
    else               sm_o = cand0;
  end
endmodule

// File: rtl/acs_feed_net.sv
module acs_feed_net #(
  parameter int NS = 16,
  parameter int WS = 12
) (
  input  logic [NS-1:0][WS-1:0] slots_i,
  input  logic                  bwd_i,
  output logic [NS-1:0][WS-1:0] op0_o,
  output logic [NS-1:0][WS-1:0] op1_o
);
  // Fixed full-size trellis wiring; smaller codes reach it through the
  // permutation network placed around the feedback register.
  for (genvar j = 0; j < NS; j++) begin : g_cell
    localparam int FA0 = (2 * j) % NS;
    localparam int FA1 = (2 * j + 1) % NS;
    localparam int BA0 = j / 2;
    localparam int BA1 = j / 2 + NS / 2;
    assign op0_o[j] = bwd_i ? slots_i[BA0] : slots_i[FA0];
    assign op1_o[j] = bwd_i ? slots_i[BA1] : slots_i[FA1];
  end
endmodule

// File: rtl/acs_perm.sv
module acs_perm
  import acs_rec_pkg::*;
#(
  parameter int NS   = 16,
  parameter int W    = 12,
  parameter int KIND = 0,
  parameter int NK   = 3,
  parameter int KW   = 2
) (
  input  logic [NS-1:0][W-1:0] din_i,
  input  logic [KW-1:0]        ksel_i,
  input  logic                 bwd_i,
  output logic [NS-1:0][W-1:0] dout_o
);
  logic [NK-1:0][NS-1:0][W-1:0] pf;
  logic [NK-1:0][NS-1:0][W-1:0] pb;

  for (genvar gk = 0; gk < NK; gk++) begin : g_k
    localparam int N = 1 << (gk + K_MIN - 1);
    for (genvar gi = 0; gi < NS; gi++) begin : g_i
      localparam int SF = src_idx(KIND, 1'b0, gi, N, NS);
      localparam int SB = src_idx(KIND, 1'b1, gi, N, NS);
      if (SF >= 0) begin : g_f
        assign pf[gk][gi] = din_i[SF];
      end else begin : g_fz
        assign pf[gk][gi] = '0;
      end
      if (SB >= 0) begin : g_b
        assign pb[gk][gi] = din_i[SB];
      end else begin : g_bz
        assign pb[gk][gi] = '0;
      end
    end
  end

  always_comb begin
    if (bwd_i) dout_o = pb[ksel_i];
    else       dout_o = pf[ksel_i];
  end
endmodule

// File: rtl/acs_recursion_bank.sv
module acs_recursion_bank
  import acs_rec_pkg::*;
#(
  parameter int NS = 16,
  parameter int WB = 6,
  parameter int WS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [2:0]       cfg_k_i,
  input  logic             cfg_bwd_i,
  input  logic             bm_vld_i,
  input  logic [NS*WB-1:0] bm0_i,
  input  logic [NS*WB-1:0] bm1_i,
  output logic [NS*WS-1:0] sm_o,
  output logic             sm_vld_o
);
  localparam int KIW   = 3;
  localparam int K_MAX = $clog2(NS) + 1;
  localparam int NK    = K_MAX - K_MIN + 1;
  localparam int KW    = (NK > 1) ? $clog2(NK) : 1;
  localparam logic [WS-1:0] NEG_INIT = {2'b11, {(WS-2){1'b0}}};

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // State
  logic [NS-1:0][WS-1:0] slot_q, slot_d;
  logic [KW-1:0]         ksel_q;
  rec_dir_e              dir_q;
  logic                  armed_q;
  logic                  vld_q, vld_d;
  logic                  upd_en;
  logic                  bwd_sel;

  // Datapath
  logic [NS-1:0][WB-1:0] bm0_l, bm1_l, bma0, bma1;
  logic [NS-1:0][WS-1:0] op0, op1, acs_out, slot_nxt, slot_init, view;
  logic [KW-1:0]         ksel_dec;
  int                    n_new;

  assign bm0_l   = bm0_i;
  assign bm1_l   = bm1_i;
  assign bwd_sel = (dir_q == DIR_BWD);

  acs_perm #(.NS(NS), .W(WB), .KIND(0), .NK(NK), .KW(KW)) u_bm0_route (
    .din_i(bm0_l), .ksel_i(ksel_q), .bwd_i(bwd_sel), .dout_o(bma0));
  acs_perm #(.NS(NS), .W(WB), .KIND(0), .NK(NK), .KW(KW)) u_bm1_route (
    .din_i(bm1_l), .ksel_i(ksel_q), .bwd_i(bwd_sel), .dout_o(bma1));

  acs_feed_net #(.NS(NS), .WS(WS)) u_feed (
    .slots_i(slot_q), .bwd_i(bwd_sel), .op0_o(op0), .op1_o(op1));

  for (genvar j = 0; j < NS; j++) begin : g_acs
    acs_cell #(.WS(WS), .WB(WB)) u_cell (
      .m0_i(op0[j]), .m1_i(op1[j]), .b0_i(bma0[j]), .b1_i(bma1[j]),
      .sm_o(acs_out[j]));
  end

  acs_perm #(.NS(NS), .W(WS), .KIND(1), .NK(NK), .KW(KW)) u_fb_map (
    .din_i(acs_out), .ksel_i(ksel_q), .bwd_i(bwd_sel), .dout_o(slot_nxt));

  acs_perm #(.NS(NS), .W(WS), .KIND(2), .NK(NK), .KW(KW)) u_view_map (
    .din_i(slot_q), .ksel_i(ksel_q), .bwd_i(bwd_sel), .dout_o(view));

  // Constraint length decode with clamping
  always_comb begin
    if (cfg_k_i <= KIW'(K_MIN))      ksel_dec = '0;
    else if (cfg_k_i >= KIW'(K_MAX)) ksel_dec = KW'(NK - 1);
    else                             ksel_dec = KW'(cfg_k_i - KIW'(K_MIN));
  end

  // Initial vector for the configuration being started
  always_comb begin
    n_new = 1 << (int'(ksel_dec) + K_MIN - 1);
    for (int s = 0; s < NS; s++) begin
      if (!cfg_bwd_i && s != 0 && s < n_new) slot_init[s] = NEG_INIT;
      else                                   slot_init[s] = '0;
    end
  end

  // Next state
  always_comb begin
    upd_en = start_i || (bm_vld_i && armed_q);
    vld_d  = upd_en;
    slot_d = start_i ? slot_init : slot_nxt;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      slot_q  <= '0;
      ksel_q  <= KW'(NK - 1);
      dir_q   <= DIR_FWD;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (upd_en) slot_q <= slot_d;
      if (start_i) begin
        ksel_q  <= ksel_dec;
        dir_q   <= rec_dir_e'(cfg_bwd_i);
        armed_q <= 1'b1;
      end
    end
  end

  assign sm_o     = view;
  assign sm_vld_o = vld_q;
endmodule

// File: rtl/acs_recursion_bank_chk.sv
module acs_recursion_bank_chk
  import acs_rec_pkg::*;
#(
  parameter int NS = 16,
  parameter int WS = 12,
  parameter int KW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             cfg_bwd_i,
  input logic             bm_vld_i,
  input logic [NS*WS-1:0] sm_o,
  input logic             sm_vld_o,
  input logic             armed_q,
  input logic [KW-1:0]    ksel_q,
  input logic             bwd_sel
);
  logic [NS*WS-1:0] idle_mask;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      idle_mask[s*WS +: WS] = (s >= (1 << (int'(ksel_q) + K_MIN - 1))) ? '1 : '0;
    end
  end

  // R2: a start always produces a valid vector next cycle
  a_r2_start_valid: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> sm_vld_o);

  // R2: forward start puts metric 0 on state 0
  a_r2_fwd_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !cfg_bwd_i) |=> (sm_o[WS-1:0] == '0));

  // R9: idle cycle holds metrics and drops valid
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !bm_vld_i) |=> (!sm_vld_o && $stable(sm_o)));

  // R8: nothing valid leaves the block before the first start
  a_r8_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !sm_vld_o);

  // R6: lanes beyond the active state count read zero
  a_r6_inactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_o & idle_mask) == '0);

  // R7: configuration only moves on start
  a_r7_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(ksel_q) && $stable(bwd_sel)));
endmodule

bind acs_recursion_bank acs_recursion_bank_chk #(.NS(NS), .WS(WS), .KW(KW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .cfg_bwd_i(cfg_bwd_i),
  .bm_vld_i(bm_vld_i), .sm_o(sm_o), .sm_vld_o(sm_vld_o), .armed_q(armed_q),
  .ksel_q(ksel_q), .bwd_sel(bwd_sel));

// File: tb/acs_recursion_bank_test.sv
module acs_recursion_bank_test;
  localparam int NS = 16;
  localparam int WB = 6;
  localparam int WS = 12;
  localparam int NEG = -(1 << (WS - 2));

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [2:0]       cfg_k_i;
  logic             cfg_bwd_i;
  logic             bm_vld_i;
  logic [NS*WB-1:0] bm0_i;
  logic [NS*WB-1:0] bm1_i;
  logic [NS*WS-1:0] sm_o;
  logic             sm_vld_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int b0 [NS];
  int b1 [NS];
  int mdl [NS];
  int mn     = 16;
  bit mbwd   = 0;
  bit marmed = 0;

  acs_recursion_bank #(.NS(NS), .WB(WB), .WS(WS)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_k_i(cfg_k_i),
    .cfg_bwd_i(cfg_bwd_i), .bm_vld_i(bm_vld_i), .bm0_i(bm0_i), .bm1_i(bm1_i),
    .sm_o(sm_o), .sm_vld_o(sm_vld_o));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int n_of(int k);
    int kk;
    kk = (k < 3) ? 3 : ((k > 5) ? 5 : k);
    return 1 << (kk - 1);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic fill_rand();
    for (int s = 0; s < NS; s++) begin
      b0[s] = int'($urandom_range(63)) - 32;
      b1[s] = int'($urandom_range(63)) - 32;
    end
  endtask

  task automatic fill_const(input int v0, input int v1);
    for (int s = 0; s < NS; s++) begin
      b0[s] = v0;
      b1[s] = v1;
    end
  endtask

  // Compare the whole output vector and valid against the model (R10 packing)
  task automatic check_out(input string req, input bit exp_vld);
    int got;
    int exp;
    bit bad;
    logic signed [WS-1:0] lane;
    checks++;
    bad = 0;
    if (sm_vld_o !== exp_vld) begin
      bad = 1;
      $display("FAIL %s: sm_vld_o actual %0b expected %0b", req, sm_vld_o, exp_vld);
    end
    for (int s = 0; s < NS; s++) begin
      lane = sm_o[s*WS +: WS];
      got  = int'(lane);
      exp  = (s < mn) ? mdl[s] : 0;
      if (!bad && got != exp) begin
        bad = 1;
        $display("FAIL %s: state %0d actual %0d expected %0d", req, s, got, exp);
      end
    end
    if (bad) errors++;
  endtask

  // Called at a falling edge: drive, let one rising edge pass, update model, check
  task automatic cycle(input bit st, input int k, input bit bw, input bit v, input string req);
    int nw [NS];
    bit ev;
    start_i   = st;
    cfg_k_i   = 3'(k);
    cfg_bwd_i = bw;
    bm_vld_i  = v;
    for (int s = 0; s < NS; s++) begin
      bm0_i[s*WB +: WB] = WB'(b0[s]);
      bm1_i[s*WB +: WB] = WB'(b1[s]);
    end
    @(negedge clk);
    ev = 0;
    if (st) begin
      mn     = n_of(k);
      mbwd   = bw;
      marmed = 1;
      ev     = 1;
      for (int s = 0; s < NS; s++) mdl[s] = (!bw && s != 0 && s < mn) ? NEG : 0;
    end else if (v && marmed) begin
      ev = 1;
      for (int s = 0; s < NS; s++) begin
        if (s >= mn) nw[s] = 0;
        else if (!mbwd)
          nw[s] = max2(mdl[(2*s) % mn] + b0[s], mdl[(2*s+1) % mn] + b1[s]);
        else
          nw[s] = max2(mdl[s/2] + b0[s], mdl[s/2 + mn/2] + b1[s]);
      end
      for (int s = 0; s < NS; s++) mdl[s] = nw[s];
    end
    check_out(req, ev);
  endtask

  initial begin
    rst_n     = 1'b0;
    start_i   = 1'b0;
    cfg_k_i   = 3'd5;
    cfg_bwd_i = 1'b0;
    bm_vld_i  = 1'b0;
    bm0_i     = '0;
    bm1_i     = '0;
    for (int s = 0; s < NS; s++) begin
      mdl[s] = 0;
      b0[s]  = 0;
      b1[s]  = 0;
    end
    repeat (3) @(negedge clk);
    check_out("R1 in reset", 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_out("R1 after release", 1'b0);

    // R8: valid before any start
    fill_rand();
    cycle(0, 5, 0, 1, "R8 valid before start");
    fill_rand();
    cycle(0, 3, 1, 1, "R8 valid before start again");

    // Sweep every constraint length in both directions
    for (int k = 3; k <= 5; k++) begin
      for (int bw = 0; bw < 2; bw++) begin
        fill_rand();
        cycle(1, k, bit'(bw), 1, "R2 start init with valid");
        for (int st = 0; st < 14; st++) begin
          fill_rand();
          if (st % 5 == 4)
            cycle(0, k, bit'(bw), 0, "R9 idle hold");
          else if (st == 7)
            cycle(0, (k == 5) ? 3 : 5, !bit'(bw), 1, "R7 config change ignored");
          else if (bw == 0)
            cycle(0, k, 1'b0, 1, "R3 forward step R6");
          else
            cycle(0, k, 1'b1, 1, "R4 backward step R6");
        end
      end
    end

    // R5: clamping of out-of-range constraint lengths
    fill_rand();
    cycle(1, 2, 0, 0, "R5 K=2 clamps to 4 states");
    fill_rand();
    cycle(0, 2, 0, 1, "R5 step with 4 states");
    fill_rand();
    cycle(1, 7, 1, 0, "R5 K=7 clamps to 16 states");
    fill_rand();
    cycle(0, 7, 1, 1, "R5 step with 16 states");
    fill_rand();
    cycle(1, 0, 1, 0, "R5 K=0 clamps to 4 states");
    fill_rand();
    cycle(0, 0, 1, 1, "R5 backward step with 4 states");

    // Extreme branch metrics: R3 and R4 signed compare
    for (int bw = 0; bw < 2; bw++) begin
      fill_const(0, 0);
      cycle(1, 4, bit'(bw), 0, "R2 start for extremes");
      for (int st = 0; st < 6; st++) begin
        if (st % 2 == 0) fill_const(-32, 31);
        else             fill_const(31, -32);
        cycle(0, 4, bit'(bw), 1, bw ? "R4 extreme metrics" : "R3 extreme metrics");
      end
    end

    start_i  = 1'b0;
    bm_vld_i = 1'b0;
    @(negedge clk);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule